// File: doc/BRIEF.md
# Asynchronous SRAM access controller

This block sits between a clocked host and an asynchronous static RAM with an 18-bit address, a 4-bit shared data bus and active-low select, write-enable and output-enable strobes. The host hands over one word-sized read or write at a time on a valid/ready port. The controller then produces the strobe sequence with every width counted in clock cycles. Read data comes back on its own port, marked by a one-cycle valid pulse.

Strobe widths are parameters in cycles, each rounded up from the RAM's nanosecond minimums at a 100 MHz clock. A read drives select and output-enable low for `RD_CYC` cycles and samples the bus in the last of them. The bus then rests for `TURN_CYC` cycles so that the RAM's drivers are off before anything else can use it. A write holds output-enable high for its whole length. It opens with write-enable low for `WP_CYC` cycles and closes with write-enable high and select still low for `WR_HOLD_CYC` cycles, with the data still driven. Only after that is select released.

The shared data bus appears as three plain ports: a value, a drive enable and the sampled input. These are wired to a pad buffer outside the block. A pulse on `power_restored` starts a wait of `REC_CYC` cycles, 5 ms by default. During that wait select stays high and ready stays low. The pulse also cuts short any access that is in flight.

Top module: `sramc_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `sram_cs_n`, `sram_we_n` and `sram_oe_n` are 1, and `sram_dq_oe` and `rd_valid` are 0.
- R2: A read is accepted on a clock edge where `req_valid` and `req_ready` are both 1 and `req_write` is 0. For the next `RD_CYC` cycles, `sram_cs_n`=0, `sram_oe_n`=0, `sram_we_n`=1, `sram_dq_oe`=0, `sram_addr` equals the request address and `req_ready`=0.
- R3: The bus is sampled at the end of the last read-strobe cycle. `rd_valid` is 1 for exactly the one cycle that starts `RD_CYC`+1 edges after acceptance, and `rd_data` then holds the word stored at that address.
- R4: After a read strobe, `sram_cs_n` and `sram_oe_n` are 1 for `TURN_CYC` cycles with `req_ready`=0. `req_ready` returns to 1 `RD_CYC`+`TURN_CYC`+1 edges after acceptance.
- R5: A write has `req_write`=1. For the `WP_CYC` cycles after acceptance, `sram_cs_n`=0, `sram_we_n`=0, `sram_oe_n`=1, `sram_dq_oe`=1, `sram_dq_out` is the write data and `sram_addr` is the request address.
- R6: After the write pulse, `sram_we_n`=1 while `sram_cs_n`=0 and `sram_dq_oe`=1 for `WR_HOLD_CYC` cycles. Then `sram_cs_n`=1, `sram_dq_oe`=0 and `req_ready`=1. The word reads back afterwards.
- R7: `sram_dq_oe` is 1 only while `sram_cs_n`=0 and `sram_oe_n`=1, and only after `sram_oe_n` has been 1 for at least `TURN_CYC` prior cycles. Drive never overlaps an enabled RAM output.
- R8: A `power_restored` pulse sampled at an edge holds `sram_cs_n`=1 and `req_ready`=0 for the following `REC_CYC` cycles. `req_ready` is 1 in the cycle after that.
- R9: A `power_restored` pulse during an access ends it: in the next cycle all strobes are 1 and `sram_dq_oe`=0, and the aborted read gives no `rd_valid`.
- R10: A request presented on the same edge as a `power_restored` pulse is dropped. No strobe falls, and the addressed word keeps its old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| power_restored | input | 1 | Pulse: supply back from retention, start recovery wait |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | DATA_W | Read data |
| sram_addr | output | ADDR_W | RAM address pins |
| sram_cs_n | output | 1 | RAM select, active low |
| sram_we_n | output | 1 | RAM write enable, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_dq_out | output | DATA_W | Value driven onto the data bus |
| sram_dq_oe | output | 1 | Data bus drive enable |
| sram_dq_in | input | DATA_W | Data bus as seen at the pad |

## Verification
The hardest situation to reach is a `power_restored` pulse that lands on the same edge as a request handshake, or inside a strobe window. From the ports this needs the pulse timed to a single edge relative to acceptance. The bench raises the pulse in the same half-cycle as `req_valid` while `req_ready` is high, or one cycle after acceptance, then watches that no strobe falls and no read data is returned. To prove the dropped write left the RAM untouched, the bench reads the same address back once recovery ends.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_STROBE,
    ST_RD_TURN,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_RECOVER
  } sramc_state_e;

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/sramc_seq.sv
module sramc_seq
  import sramc_pkg::*;
#(
  parameter int unsigned CNT_W       = 20,
  parameter int unsigned RD_CYC      = 2,
  parameter int unsigned WP_CYC      = 1,
  parameter int unsigned WR_HOLD_CYC = 1,
  parameter int unsigned TURN_CYC    = 1,
  parameter int unsigned REC_CYC     = 500000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pwr,
  input  logic             fire,
  input  logic             fire_write,
  input  logic             done,
  output sramc_state_e     state_q,
  output sramc_state_e     state_nxt,
  output logic             load,
  output logic [CNT_W-1:0] load_val
);

  localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_WP   = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] LD_HOLD = CNT_W'(WR_HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(TURN_CYC - 1);
  localparam logic [CNT_W-1:0] LD_REC  = CNT_W'(REC_CYC - 1);

  always_comb begin
    state_nxt = state_q;
    load      = 1'b0;
    load_val  = '0;
    if (pwr) begin
      state_nxt = ST_RECOVER;
      load      = 1'b1;
      load_val  = LD_REC;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (fire) begin
            load = 1'b1;
            if (fire_write) begin
              state_nxt = ST_WR_PULSE;
              load_val  = LD_WP;
            end else begin
              state_nxt = ST_RD_STROBE;
              load_val  = LD_RD;
            end
          end
        end
        ST_RD_STROBE: begin
          if (done) begin
            state_nxt = ST_RD_TURN;
            load      = 1'b1;
            load_val  = LD_TURN;
          end
        end
        ST_RD_TURN: begin
          if (done) state_nxt = ST_IDLE;
        end
        ST_WR_PULSE: begin
          if (done) begin
            state_nxt = ST_WR_HOLD;
            load      = 1'b1;
            load_val  = LD_HOLD;
          end
        end
        ST_WR_HOLD: begin
          if (done) state_nxt = ST_IDLE;
        end
        ST_RECOVER: begin
          if (done) state_nxt = ST_IDLE;
        end
        default: state_nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_IDLE;
    else     state_q <= state_nxt;
  end

endmodule

// File: rtl/sramc_pins.sv
module sramc_pins
  import sramc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 18,
  parameter int unsigned DATA_W   = 4,
  parameter int unsigned TURN_CYC = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  sramc_state_e      state_nxt,
  input  logic              fire,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              req_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe
);

  localparam int unsigned QW = $clog2(TURN_CYC + 1) + 1;
  localparam logic [QW-1:0] Q_SAT = QW'(TURN_CYC);

  logic [QW-1:0] quiet_q;
  logic [QW-1:0] quiet_nxt;
  logic          bus_free;
  logic          nxt_sel;
  logic          nxt_wr;

  // cycles the RAM output enable has been off, counting the current one
  always_comb begin
    if (!sram_oe_n)           quiet_nxt = '0;
    else if (quiet_q >= Q_SAT) quiet_nxt = Q_SAT;
    else                       quiet_nxt = quiet_q + 1'b1;
  end

  assign bus_free = (quiet_nxt >= Q_SAT);
  assign nxt_wr   = (state_nxt == ST_WR_PULSE) || (state_nxt == ST_WR_HOLD);
  assign nxt_sel  = nxt_wr || (state_nxt == ST_RD_STROBE);

  always_ff @(posedge clk) begin
    if (rst) begin
      quiet_q     <= Q_SAT;
      req_ready   <= 1'b1;
      sram_cs_n   <= 1'b1;
      sram_we_n   <= 1'b1;
      sram_oe_n   <= 1'b1;
      sram_dq_oe  <= 1'b0;
      sram_addr   <= '0;
      sram_dq_out <= '0;
      rd_valid    <= 1'b0;
      rd_data     <= '0;
    end else begin
      quiet_q    <= quiet_nxt;
      req_ready  <= (state_nxt == ST_IDLE);
      sram_cs_n  <= !nxt_sel;
      sram_we_n  <= (state_nxt != ST_WR_PULSE);
      sram_oe_n  <= (state_nxt != ST_RD_STROBE);
      sram_dq_oe <= nxt_wr && bus_free;
      if (fire) begin
        sram_addr   <= req_addr;
        sram_dq_out <= req_wdata;
      end
      rd_valid <= capture;
      if (capture) rd_data <= sram_dq_in;
    end
  end

endmodule

// File: rtl/sramc_ctrl.sv
module sramc_ctrl
  import sramc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 18,
  parameter int unsigned DATA_W      = 4,
  parameter int unsigned RD_CYC      = 2,
  parameter int unsigned WP_CYC      = 1,
  parameter int unsigned WR_HOLD_CYC = 1,
  parameter int unsigned TURN_CYC    = 1,
  parameter int unsigned REC_CYC     = 500000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              power_restored,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);

  localparam int unsigned MAX_LEN =
    max2(max2(max2(RD_CYC, WP_CYC), max2(WR_HOLD_CYC, TURN_CYC)), REC_CYC);
  localparam int unsigned CNT_W = $clog2(MAX_LEN + 1);

  sramc_state_e     state_q;
  sramc_state_e     state_nxt;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             done;
  logic             fire;
  logic             capture;

  assign fire    = req_valid && req_ready;
  assign capture = (state_q == ST_RD_STROBE) && done && !power_restored;

  sramc_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .done     (done)
  );

  sramc_seq #(
    .CNT_W       (CNT_W),
    .RD_CYC      (RD_CYC),
    .WP_CYC      (WP_CYC),
    .WR_HOLD_CYC (WR_HOLD_CYC),
    .TURN_CYC    (TURN_CYC),
    .REC_CYC     (REC_CYC)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .pwr        (power_restored),
    .fire       (fire),
    .fire_write (req_write),
    .done       (done),
    .state_q    (state_q),
    .state_nxt  (state_nxt),
    .load       (load),
    .load_val   (load_val)
  );

  sramc_pins #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .TURN_CYC (TURN_CYC)
  ) u_pins (
    .clk         (clk),
    .rst         (rst),
    .state_nxt   (state_nxt),
    .fire        (fire),
    .capture     (capture),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .sram_dq_in  (sram_dq_in),
    .req_ready   (req_ready),
    .rd_valid    (rd_valid),
    .rd_data     (rd_data),
    .sram_addr   (sram_addr),
    .sram_cs_n   (sram_cs_n),
    .sram_we_n   (sram_we_n),
    .sram_oe_n   (sram_oe_n),
    .sram_dq_out (sram_dq_out),
    .sram_dq_oe  (sram_dq_oe)
  );

endmodule

// File: rtl/sramc_ctrl_checker.sv
module sramc_ctrl_checker #(
  parameter int unsigned TURN_CYC = 1,
  parameter int unsigned REC_CYC  = 500000
) (
  input logic clk,
  input logic rst,
  input logic power_restored,
  input logic req_ready,
  input logic rd_valid,
  input logic sram_cs_n,
  input logic sram_we_n,
  input logic sram_oe_n,
  input logic sram_dq_oe
);

  int unsigned oe_hi_cnt;
  int unsigned rec_left;

  always_ff @(posedge clk) begin
    if (rst) begin
      oe_hi_cnt <= TURN_CYC;
      rec_left  <= 0;
    end else begin
      if (!sram_oe_n)                oe_hi_cnt <= 0;
      else if (oe_hi_cnt < TURN_CYC) oe_hi_cnt <= oe_hi_cnt + 1;
      if (power_restored)     rec_left <= REC_CYC;
      else if (rec_left != 0) rec_left <= rec_left - 1;
    end
  end

  AST_OE_NEEDS_CS: assert property (@(posedge clk) disable iff (rst)
    !sram_oe_n |-> (!sram_cs_n && sram_we_n)); // R2
  AST_RDV_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid); // R3
  AST_READY_PINS_IDLE: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe)); // R4
  AST_WRITE_OE_HIGH: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> (!sram_cs_n && sram_oe_n && sram_dq_oe)); // R5
  AST_WE_CLOSES_FIRST: assert property (@(posedge clk) disable iff (rst)
    ($rose(sram_cs_n) && !$past(power_restored)) |-> $past(sram_we_n)); // R6
  AST_DRIVE_BUS_FREE: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> (!sram_cs_n && sram_oe_n && oe_hi_cnt >= TURN_CYC)); // R7
  AST_RECOVER_QUIET: assert property (@(posedge clk) disable iff (rst)
    (rec_left != 0) |-> (sram_cs_n && !req_ready)); // R8
  AST_ABORT_RELEASE: assert property (@(posedge clk) disable iff (rst)
    power_restored |=> (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe)); // R9

endmodule

bind sramc_ctrl sramc_ctrl_checker #(
  .TURN_CYC (TURN_CYC),
  .REC_CYC  (REC_CYC)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .power_restored (power_restored),
  .req_ready      (req_ready),
  .rd_valid       (rd_valid),
  .sram_cs_n      (sram_cs_n),
  .sram_we_n      (sram_we_n),
  .sram_oe_n      (sram_oe_n),
  .sram_dq_oe     (sram_dq_oe)
);

// File: tb/sramc_ctrl_bench.sv
module sramc_ctrl_bench;

  localparam int AW   = 18;
  localparam int DW   = 4;
  localparam int RD   = 2;
  localparam int WP   = 1;
  localparam int HOLD = 1;
  localparam int TURN = 1;
  localparam int REC  = 20;
  localparam int NVEC = 10;

  // vector: {write, addr[17:0], data[3:0]}; reads expect the bench shadow copy
  localparam logic [22:0] VEC [NVEC] = '{
    {1'b1, 18'h3FF05, 4'hA},
    {1'b1, 18'h00012, 4'h3},
    {1'b0, 18'h3FF05, 4'h0},
    {1'b0, 18'h00012, 4'h0},
    {1'b1, 18'h15527, 4'hC},
    {1'b0, 18'h15527, 4'h0},
    {1'b1, 18'h00012, 4'hF},
    {1'b0, 18'h00012, 4'h0},
    {1'b0, 18'h3FF05, 4'h0},
    {1'b0, 18'h00031, 4'h0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          power_restored = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          req_ready;
  logic          rd_valid;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] sram_addr;
  logic          sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe;
  logic [DW-1:0] sram_dq_out;
  logic [DW-1:0] sram_dq_in;

  int checks = 0;
  int fails = 0;
  int contention = 0;
  bit finished = 0;

  logic [DW-1:0] mem    [64];
  logic [DW-1:0] shadow [64];

  always #2 clk = ~clk;

  sramc_ctrl #(
    .ADDR_W(AW), .DATA_W(DW), .RD_CYC(RD), .WP_CYC(WP),
    .WR_HOLD_CYC(HOLD), .TURN_CYC(TURN), .REC_CYC(REC)
  ) u_sramc_ctrl (
    .clk(clk), .rst(rst), .power_restored(power_restored),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .sram_addr(sram_addr), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe),
    .sram_dq_in(sram_dq_in)
  );

  // RAM model: write ends as WE rises while selected and driven
  always @(posedge sram_we_n) begin
    if (!sram_cs_n && sram_dq_oe) mem[sram_addr[5:0]] <= sram_dq_out;
  end
  assign sram_dq_in = (!sram_cs_n && !sram_oe_n && sram_we_n) ? mem[sram_addr[5:0]] : 4'h5;

  always @(negedge clk) begin
    if (sram_dq_oe && !sram_cs_n && !sram_oe_n) contention++;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // leaves the bench at the negedge of the first cycle after acceptance
  task automatic issue(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
    issue(1'b0, a, 4'h0);
    for (int k = 1; k <= RD; k++) begin
      chk("R2 cs_n", sram_cs_n, 0);
      chk("R2 oe_n", sram_oe_n, 0);
      chk("R2 we_n", sram_we_n, 1);
      chk("R2 addr", sram_addr, a);
      chk("R2 ready", req_ready, 0);
      chk("R3 no early valid", rd_valid, 0);
      if (k < RD) @(negedge clk);
    end
    @(negedge clk);
    chk("R3 rd_valid", rd_valid, 1);
    chk("R3 rd_data", rd_data, exp);
    chk("R4 cs_n turn", sram_cs_n, 1);
    chk("R4 oe_n turn", sram_oe_n, 1);
    chk("R4 ready turn", req_ready, 0);
    for (int t = 2; t <= TURN; t++) begin
      @(negedge clk);
      chk("R4 ready turn", req_ready, 0);
    end
    @(negedge clk);
    chk("R3 single pulse", rd_valid, 0);
    chk("R4 ready back", req_ready, 1);
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    issue(1'b1, a, d);
    for (int k = 1; k <= WP; k++) begin
      chk("R5 we_n", sram_we_n, 0);
      chk("R5 cs_n", sram_cs_n, 0);
      chk("R5 oe_n", sram_oe_n, 1);
      chk("R5 dq_oe", sram_dq_oe, 1);
      chk("R5 dq_out", sram_dq_out, d);
      chk("R5 addr", sram_addr, a);
      @(negedge clk);
    end
    for (int k = 1; k <= HOLD; k++) begin
      chk("R6 we_n hold", sram_we_n, 1);
      chk("R6 cs_n hold", sram_cs_n, 0);
      chk("R6 dq_oe hold", sram_dq_oe, 1);
      @(negedge clk);
    end
    chk("R6 cs_n release", sram_cs_n, 1);
    chk("R6 dq_oe release", sram_dq_oe, 0);
    chk("R6 ready back", req_ready, 1);
    shadow[a[5:0]] = d;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin mem[i] = '0; shadow[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;

    // R1 reset state
    chk("R1 ready", req_ready, 1);
    chk("R1 cs_n", sram_cs_n, 1);
    chk("R1 we_n", sram_we_n, 1);
    chk("R1 oe_n", sram_oe_n, 1);
    chk("R1 dq_oe", sram_dq_oe, 0);
    chk("R1 rd_valid", rd_valid, 0);

    // vector walk
    for (int v = 0; v < NVEC; v++) begin
      if (VEC[v][22]) do_write(VEC[v][21:4], VEC[v][3:0]);
      else            do_read(VEC[v][21:4], shadow[VEC[v][9:4]]);
    end

    // R8 recovery wait
    @(negedge clk);
    power_restored = 1'b1;
    @(negedge clk);
    power_restored = 1'b0;
    begin
      int bad = 0;
      for (int k = 1; k <= REC; k++) begin
        if (req_ready || !sram_cs_n) bad++;
        if (k < REC) @(negedge clk);
      end
      chk("R8 held during wait", bad, 0);
    end
    @(negedge clk);
    chk("R8 ready after wait", req_ready, 1);

    // R9 abort a read in its strobe
    issue(1'b0, 18'h3FF05, 4'h0);
    chk("R9 read started", sram_oe_n, 0);
    power_restored = 1'b1;
    @(negedge clk);
    power_restored = 1'b0;
    chk("R9 cs_n", sram_cs_n, 1);
    chk("R9 oe_n", sram_oe_n, 1);
    begin
      int seen = 0;
      for (int k = 0; k < REC + 2; k++) begin
        if (rd_valid) seen++;
        @(negedge clk);
      end
      chk("R9 no rd_valid", seen, 0);
    end

    // R9 abort a write in its pulse
    issue(1'b1, 18'h00031, 4'h9);
    chk("R9 write started", sram_we_n, 0);
    power_restored = 1'b1;
    @(negedge clk);
    power_restored = 1'b0;
    chk("R9 we_n", sram_we_n, 1);
    chk("R9 dq_oe", sram_dq_oe, 0);
    shadow[6'h31] = mem[6'h31];
    repeat (REC + 1) @(negedge clk);

    // R10 request coincident with power_restored
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00012; req_wdata = 4'h6;
    power_restored = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; power_restored = 1'b0;
    begin
      int lows = 0;
      for (int k = 1; k <= REC; k++) begin
        if (!sram_we_n || !sram_cs_n) lows++;
        @(negedge clk);
      end
      chk("R10 no strobe", lows, 0);
    end
    do_read(18'h00012, shadow[6'h12]);
    chk("R10 old word kept", rd_data, 4'hF);

    // R7 no drive against enabled RAM output anywhere in the run
    chk("R7 contention", contention, 0);
    // R6 read back of a word written just after a read
    do_write(18'h00027, 4'h1);
    do_read(18'h00027, 4'h1);

    finish_run();
  end

endmodule